// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets clocked logic use an external static RAM that has no clock of its own. It takes one request at a time over a valid/ready handshake. Each request carries an address, a read/write flag, write data and a per-byte lane mask. The block then drives the memory's active-low select, write strobe, output enable and per-lane byte enables. Every strobe and the bus-drive control comes straight from a flop. Read data returns with a single-cycle valid pulse.

The bus timing is set in nanoseconds through parameters. The block turns each value into a clock-cycle count: the ceiling of the time divided by the clock period, with a floor of one cycle. Writes are strobed by the write enable while output enable stays high. A read always ends with a turnaround phase, so the memory's drivers are off before the block can drive the bus again. The data bus is split into a driven value, a drive-enable and the value seen on the pins; the pad-level tristate sits outside this block.

States: `ST_IDLE`, `ST_READ_WAIT`, `ST_READ_CAPTURE`, `ST_WRITE_SETUP`, `ST_WRITE_PULSE`, `ST_WRITE_RECOVER`, `ST_TURNAROUND`. Transitions:
- IDLE→READ_WAIT on an accepted read.
- IDLE→WRITE_SETUP on an accepted write.
- READ_WAIT→READ_CAPTURE when the access count expires.
- READ_CAPTURE→TURNAROUND unconditionally.
- TURNAROUND→IDLE when the turnaround count expires.
- WRITE_SETUP→WRITE_PULSE unconditionally.
- WRITE_PULSE→WRITE_RECOVER when the pulse count expires.
- WRITE_RECOVER→IDLE unconditionally.

Top module: `sram_bridge`

## Requirements
- R1: After reset and whenever `req_ready` is high, the memory is in standby. `sram_cs_n`, `sram_we_n` and `sram_oe_n` are high, both bits of `sram_be_n` are high, and `sram_dq_oe` is low.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the operation and any turnaround are complete.
- R3: For a read, `sram_cs_n` and `sram_oe_n` are low and `sram_we_n` is high for ACC+1 cycles, starting at the accept edge. `rsp_valid` is high for exactly one cycle, starting ACC+1 edges after the accept edge. Output enable stays low for at least the access time.
- R4: Mask bit 0 selects lane bits 7..0 and drives `sram_be_n[0]` low. Mask bit 1 selects bits 15..8 and drives `sram_be_n[1]` low. `rsp_rdata` carries the bus value on the selected lanes and zero on deselected lanes.
- R5: A write proceeds in three phases. First, one setup cycle with data driven and `sram_we_n` high. Then `sram_we_n` is low for WP cycles. Last, one recover cycle. `sram_oe_n` stays high throughout, and the data is driven at least the setup time before `sram_we_n` rises.
- R6: A write changes only the lanes whose mask bits are set. The other lane of the addressed word keeps its value.
- R7: Address, byte enables and driven data are stable for the whole time `sram_we_n` is low and at its rising edge.
- R8: After `sram_oe_n` rises, `sram_dq_oe` stays low for at least TURN cycles. A read is followed by a TURN-cycle turnaround before `req_ready` returns.
- R9: With a zero mask, a write leaves memory unchanged and a read returns zero with the usual latency.
- R10: ACC, WP and TURN each equal ceil(time / `CLK_NS`), with a minimum of 1. At the defaults (8 ns clock; 10, 7 and 5 ns) they are 2, 1 and 1.
- R11: `sram_dq_oe` is never high while `sram_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Lane mask, bit 0 = bits 7..0 |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DATA_W | Read data, deselected lanes zero |
| sram_addr | output | ADDR_W | Memory address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | DATA_W/8 | Byte enables, active low, bit 0 = low lane |
| sram_dq_out | output | DATA_W | Data driven onto the bus |
| sram_dq_oe | output | 1 | Bus drive enable |
| sram_dq_in | input | DATA_W | Data seen on the bus |

## Verification
Every result is due a fixed number of edges after the accept edge A. The read strobes appear right after A. `rsp_valid` rises ACC+1 edges after A, and `req_ready` returns ACC+TURN+1 edges after A. For a write, the strobe falls one edge after A and rises WP edges later, and `req_ready` returns WP+2 edges after A.

The bench drives and samples on falling edges only. It walks one falling edge at a time from A and checks each phase in the exact cycle where its value is due. The memory model timestamps strobe edges to check nanosecond widths, setup and turnaround.

// File: rtl/sram_bridge_pkg.sv
`timescale 1ns/1ps
package sram_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_WAIT,
        ST_READ_CAPTURE,
        ST_WRITE_SETUP,
        ST_WRITE_PULSE,
        ST_WRITE_RECOVER,
        ST_TURNAROUND
    } bridge_state_t;

    // Cycles needed to cover a delay: ceiling of ns / period, at least one.
    function automatic int unsigned phase_cycles(input int unsigned delay_ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (delay_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val - 1'b1;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == '0);

endmodule

// File: rtl/sram_req_hold.sv
`timescale 1ns/1ps
module sram_req_hold #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [LANES-1:0]  in_mask,
    output logic              cur_write,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic [LANES-1:0]  cur_mask
);

    logic              held_write;
    logic [ADDR_W-1:0] held_addr;
    logic [DATA_W-1:0] held_wdata;
    logic [LANES-1:0]  held_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_write <= 1'b0;
            held_addr  <= '0;
            held_wdata <= '0;
            held_mask  <= '0;
        end else if (take) begin
            held_write <= in_write;
            held_addr  <= in_addr;
            held_wdata <= in_wdata;
            held_mask  <= in_mask;
        end
    end

    // On the accept cycle the live request is used, afterwards the held copy.
    assign cur_write = take ? in_write : held_write;
    assign cur_addr  = take ? in_addr  : held_addr;
    assign cur_wdata = take ? in_wdata : held_wdata;
    assign cur_mask  = take ? in_mask  : held_mask;

endmodule

// File: rtl/sram_lane_merge.sv
`timescale 1ns/1ps
module sram_lane_merge #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANES  = 2
) (
    input  logic [DATA_W-1:0] bus_i,
    input  logic [LANES-1:0]  mask_i,
    output logic [DATA_W-1:0] data_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign data_o[g*8 +: 8] = mask_i[g] ? bus_i[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/sram_bridge.sv
`timescale 1ns/1ps
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CLK_NS    = 8,
    parameter int unsigned T_ACC_NS  = 10,
    parameter int unsigned T_WP_NS   = 7,
    parameter int unsigned T_TURN_NS = 5,
    localparam int unsigned LANES    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [LANES-1:0]  sram_be_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int unsigned ACC_CYC  = phase_cycles(T_ACC_NS, CLK_NS);
    localparam int unsigned WP_CYC   = phase_cycles(T_WP_NS, CLK_NS);
    localparam int unsigned TURN_CYC = phase_cycles(T_TURN_NS, CLK_NS);
    localparam int unsigned MAX_A    = (ACC_CYC > WP_CYC) ? ACC_CYC : WP_CYC;
    localparam int unsigned MAX_CYC  = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

    bridge_state_t state, state_next;

    logic              accept;
    logic              timer_load;
    logic [CNT_W-1:0]  timer_val;
    logic              timer_done;
    logic              cur_write;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic [LANES-1:0]  cur_mask;
    logic [DATA_W-1:0] merged;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    sram_req_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (accept),
        .in_write  (req_write),
        .in_addr   (req_addr),
        .in_wdata  (req_wdata),
        .in_mask   (req_mask),
        .cur_write (cur_write),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .cur_mask  (cur_mask)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .done     (timer_done)
    );

    sram_lane_merge #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_merge (
        .bus_i  (sram_dq_in),
        .mask_i (cur_mask),
        .data_o (merged)
    );

    // Next-state decode.
    always_comb begin
        state_next = state;
        unique case (state)
            ST_IDLE:          if (accept) state_next = cur_write ? ST_WRITE_SETUP : ST_READ_WAIT;
            ST_READ_WAIT:     if (timer_done) state_next = ST_READ_CAPTURE;
            ST_READ_CAPTURE:  state_next = ST_TURNAROUND;
            ST_WRITE_SETUP:   state_next = ST_WRITE_PULSE;
            ST_WRITE_PULSE:   if (timer_done) state_next = ST_WRITE_RECOVER;
            ST_WRITE_RECOVER: state_next = ST_IDLE;
            ST_TURNAROUND:    if (timer_done) state_next = ST_IDLE;
            default:          state_next = ST_IDLE;
        endcase
    end

    // Timer is loaded when entering a counted phase.
    always_comb begin
        timer_load = 1'b0;
        timer_val  = CNT_W'(1);
        if (state_next != state) begin
            unique case (state_next)
                ST_READ_WAIT:   begin timer_load = 1'b1; timer_val = CNT_W'(ACC_CYC);  end
                ST_WRITE_PULSE: begin timer_load = 1'b1; timer_val = CNT_W'(WP_CYC);   end
                ST_TURNAROUND:  begin timer_load = 1'b1; timer_val = CNT_W'(TURN_CYC); end
                default:        timer_load = 1'b0;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_next;
    end

    // Registered memory-side outputs, decoded from the state being entered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sram_cs_n   <= 1'b1;
            sram_we_n   <= 1'b1;
            sram_oe_n   <= 1'b1;
            sram_be_n   <= '1;
            sram_dq_oe  <= 1'b0;
            sram_addr   <= '0;
            sram_dq_out <= '0;
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
        end else begin
            if (accept) begin
                sram_addr   <= cur_addr;
                sram_dq_out <= cur_wdata;
            end
            rsp_valid <= (state == ST_READ_CAPTURE);
            if (state == ST_READ_CAPTURE) rsp_rdata <= merged;
            unique case (state_next)
                ST_READ_WAIT, ST_READ_CAPTURE: begin
                    sram_cs_n  <= 1'b0;
                    sram_we_n  <= 1'b1;
                    sram_oe_n  <= 1'b0;
                    sram_be_n  <= ~cur_mask;
                    sram_dq_oe <= 1'b0;
                end
                ST_WRITE_SETUP, ST_WRITE_RECOVER: begin
                    sram_cs_n  <= 1'b0;
                    sram_we_n  <= 1'b1;
                    sram_oe_n  <= 1'b1;
                    sram_be_n  <= ~cur_mask;
                    sram_dq_oe <= 1'b1;
                end
                ST_WRITE_PULSE: begin
                    sram_cs_n  <= 1'b0;
                    sram_we_n  <= 1'b0;
                    sram_oe_n  <= 1'b1;
                    sram_be_n  <= ~cur_mask;
                    sram_dq_oe <= 1'b1;
                end
                default: begin
                    sram_cs_n  <= 1'b1;
                    sram_we_n  <= 1'b1;
                    sram_oe_n  <= 1'b1;
                    sram_be_n  <= '1;
                    sram_dq_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sram_bridge_chk.sv
`timescale 1ns/1ps
module sram_bridge_chk #(
    parameter int unsigned TURN_CYC = 1,
    parameter int unsigned LANES    = 2,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              sram_cs_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic [LANES-1:0]  sram_be_n,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic              sram_dq_oe
);

    localparam logic [7:0] GAP_SAT = 8'hFF;
    logic [7:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              gap <= GAP_SAT;
        else if (!sram_oe_n)     gap <= '0;
        else if (gap != GAP_SAT) gap <= gap + 1'b1;
    end

    // R1
    idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_cs_n && sram_we_n && sram_oe_n && (&sram_be_n) && !sram_dq_oe));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5
    write_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_oe_n && !sram_cs_n && sram_dq_oe));

    // R7
    write_window_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> ($stable(sram_addr) && $stable(sram_dq_out) && $stable(sram_be_n)));

    // R8
    turnaround_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (gap >= TURN_CYC));

    // R11
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_dq_oe && !sram_oe_n));

endmodule

bind sram_bridge sram_bridge_chk #(
    .TURN_CYC (TURN_CYC),
    .LANES    (LANES),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .sram_cs_n   (sram_cs_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_be_n   (sram_be_n),
    .sram_addr   (sram_addr),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
);

// File: tb/test_sram_bridge.sv
`timescale 1ns/1ps
module test_sram_bridge;

    // R10: ceil(10/8)=2, ceil(7/8)=1, ceil(5/8)=1
    localparam int ACC_EXP  = 2;
    localparam int WP_EXP   = 1;
    localparam int TURN_EXP = 1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [15:0] req_addr, req_wdata;
    logic [1:0]  req_mask;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] sram_addr;
    logic        sram_cs_n, sram_we_n, sram_oe_n;
    logic [1:0]  sram_be_n;
    logic [15:0] sram_dq_out;
    logic        sram_dq_oe;
    logic [15:0] sram_dq_in;

    always #4 clk = ~clk;

    sram_bridge i_sram_bridge (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_be_n(sram_be_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", rq, act, exp, $time);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [15:0] mem    [logic [15:0]];
    logic [15:0] shadow [logic [15:0]];

    function automatic logic [15:0] mem_rd(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] shd_rd(input logic [15:0] a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] lane_mix(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] m);
        return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
    endfunction

    always @* begin
        logic [15:0] w;
        w = mem_rd(sram_addr);
        if (!sram_cs_n && !sram_oe_n && sram_we_n)
            sram_dq_in = {sram_be_n[1] ? 8'hA5 : w[15:8], sram_be_n[0] ? 8'h5A : w[7:0]};
        else
            sram_dq_in = 16'hC3C3;
    end

    realtime     t_wf, t_of, t_dqr;
    realtime     t_or = -100.0;
    logic [15:0] a_wf, d_wf;
    logic [1:0]  b_wf;
    bit          w_armed = 0, o_armed = 0;

    always @(negedge sram_we_n) if (rst_n === 1'b1) begin
        t_wf = $realtime; a_wf = sram_addr; d_wf = sram_dq_out; b_wf = sram_be_n; w_armed = 1;
    end

    always @(posedge sram_we_n) if (w_armed) begin
        w_armed = 0;
        chk($realtime - t_wf >= 7.0, "R5 pulse width", int'($realtime - t_wf), 7);
        chk($realtime - t_dqr >= 5.0, "R5 data setup", int'($realtime - t_dqr), 5);
        chk(sram_oe_n === 1'b1, "R5 oe high in write", sram_oe_n, 1);
        chk(sram_addr === a_wf && sram_be_n === b_wf, "R7 addr/be stable", sram_addr, a_wf);
        chk(sram_dq_out === d_wf && sram_dq_oe === 1'b1, "R7 data stable", sram_dq_out, d_wf);
        if (!sram_cs_n)
            mem[sram_addr] = lane_mix(mem_rd(sram_addr), sram_dq_out, ~sram_be_n);
    end

    always @(negedge sram_oe_n) if (rst_n === 1'b1) begin
        t_of = $realtime; o_armed = 1;
    end

    always @(posedge sram_oe_n) if (o_armed) begin
        o_armed = 0;
        chk($realtime - t_of >= 10.0, "R3 access time", int'($realtime - t_of), 10);
        t_or = $realtime;
    end

    always @(posedge sram_dq_oe) if (rst_n === 1'b1) begin
        t_dqr = $realtime;
        chk($realtime - t_or >= 5.0, "R8 bus turnaround", int'($realtime - t_or), 5);
    end

    always @(negedge clk) if (rst_n === 1'b1 && sram_dq_oe && !sram_oe_n)
        chk(1'b0, "R11 bus contention", {sram_dq_oe, sram_oe_n}, 32'h2);

    // ---------------- expected values ----------------
    function automatic logic [15:0] exp_read(input logic [15:0] a, input logic [1:0] m);
        logic [15:0] w;
        w = shd_rd(a);
        return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
    endfunction

    task automatic check_idle(input string rq);
        chk(req_ready && sram_cs_n && sram_we_n && sram_oe_n && sram_be_n == 2'b11 && !sram_dq_oe && !rsp_valid,
            rq, {req_ready, sram_cs_n, sram_we_n, sram_oe_n, sram_be_n, sram_dq_oe, rsp_valid}, 32'hFC);
    endtask

    // Called at a falling edge; leaves at the falling edge where ready is back.
    task automatic run_op(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
        logic [15:0] e;
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R2 busy after accept", req_ready, 0);
        if (wr) begin
            chk(!sram_cs_n && sram_we_n && sram_oe_n && sram_dq_oe && sram_be_n == ~m
                && sram_dq_out == d && sram_addr == a, "R5 setup phase",
                {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, sram_be_n}, {3'b011, 1'b1, ~m});
            repeat (WP_EXP) begin
                @(negedge clk);
                chk(!sram_we_n && sram_oe_n, "R5 strobe low", {sram_we_n, sram_oe_n}, 32'h1);
            end
            @(negedge clk);
            chk(sram_we_n && !sram_cs_n && sram_dq_oe && !req_ready, "R5 recover phase",
                {sram_we_n, sram_cs_n, sram_dq_oe}, 32'h5);
            @(negedge clk);
            check_idle("R1 idle after write");
            shadow[a] = lane_mix(shd_rd(a), d, m);
        end else begin
            chk(!sram_cs_n && !sram_oe_n && sram_we_n && sram_be_n == ~m && !sram_dq_oe
                && sram_addr == a, "R4 read strobes/lanes",
                {sram_cs_n, sram_oe_n, sram_we_n, sram_be_n}, {3'b001, ~m});
            repeat (ACC_EXP) @(negedge clk);
            chk(!rsp_valid && !sram_oe_n, "R3 no early response", {rsp_valid, sram_oe_n}, 0);
            @(negedge clk);
            e = exp_read(a, m);
            chk(rsp_valid === 1'b1, "R3 response latency", rsp_valid, 1);
            if (m == 2'b00) chk(rsp_rdata === e, "R9 zero-mask read", rsp_rdata, e);
            else            chk(rsp_rdata === e, "R4 read data", rsp_rdata, e);
            chk(!req_ready && sram_oe_n && !sram_dq_oe, "R8 turnaround held",
                {req_ready, sram_oe_n, sram_dq_oe}, 32'h2);
            repeat (TURN_EXP) @(negedge clk);
            check_idle("R8 ready after turnaround");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_mask = '0;
        repeat (3) @(negedge clk);
        check_idle("R1 during reset");
        rst_n = 1;
        @(negedge clk);
        check_idle("R1 after reset");

        // directed
        run_op(1, 16'h0005, 16'h1234, 2'b11);
        run_op(0, 16'h0005, 16'h0000, 2'b11);
        run_op(1, 16'h0005, 16'hABCD, 2'b01);   // R6 low lane only
        run_op(0, 16'h0005, 16'h0000, 2'b11);   // R6 expect 12CD
        run_op(0, 16'h0005, 16'h0000, 2'b10);   // R4 high lane only
        run_op(1, 16'h0005, 16'hFFFF, 2'b00);   // R9 zero-mask write
        run_op(0, 16'h0005, 16'h0000, 2'b11);   // R9 unchanged
        run_op(0, 16'h0005, 16'h0000, 2'b00);   // R9 zero-mask read
        run_op(1, 16'h0005, 16'h77EE, 2'b10);   // R6 high lane only
        run_op(0, 16'h0005, 16'h0000, 2'b11);
        run_op(1, 16'hFFFF, 16'hBEEF, 2'b11);   // top address
        run_op(0, 16'hFFFF, 16'h0000, 2'b01);

        // random mixed traffic
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            a = 16'($urandom_range(0, 31));
            run_op(1'($urandom_range(0, 1)), a, 16'($urandom), 2'($urandom_range(0, 3)));
        end
        for (int i = 0; i < 32; i++) run_op(0, 16'(i), 16'h0000, 2'b11);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule